// File: doc/BRIEF.md
# DDR Read Burst Truncation Tracker

This block follows one bank of a double-data-rate DRAM through its command stream and works out, cycle by cycle, which read data words actually reach the data bus. A burst of eight words leaves the device two words per clock. It starts a fixed CAS latency after the read command is sampled. A precharge to the same bank may arrive while the burst is still running. If it comes late enough, it has no effect on the data. If it comes earlier, the data window closes a CAS latency after the precharge edge, and the remaining words are never driven.

The tracker reports a per-word valid strobe and a bus drive enable that is low whenever the bus must float. It also reports how many words the most recent burst delivered and a flag for a burst that ended short. The bank's precharge recovery time is enforced: an activate that arrives too early is flagged and discarded. A read to a bank that is not open is flagged and produces no data. A surrounding controller model or a protocol monitor uses these outputs to predict bus ownership and to catch command sequences that break the timing rules.

Top module: `rd_burst_tracker`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the cycle after it is applied, the bank is closed and wordValid, outEnable, wordCount, truncated, actViolation and readError are all zero.
- R2: Commands are encoded on cmd as 0 = no operation, 1 = activate, 2 = read, 3 = precharge. A command whose bankSel differs from TRACK_BANK has no effect on any output.
- R3: An activate to the tracked bank while it is idle opens it: bankActive is high from the cycle after that edge.
- R4: A read accepted at edge e0 makes both bits of wordValid high in the cycles that follow edges e0+CAS_LAT through e0+CAS_LAT+BURST_LEN/2-1, one word pair per cycle, provided no precharge cuts it short. Both lanes are always high or low together.
- R5: A precharge to the open bank at edge e0+d, with d >= 1 and the data window still running, ends the window at edge e0+d+CAS_LAT. Only pairs whose cycle starts before that edge are driven, so min(d, BURST_LEN/2) pairs are delivered.
- R6: Once a burst's window has ended, wordCount equals the number of words driven and truncated is high exactly when that number is below BURST_LEN. Both values are cleared by the next accepted read, and wordCount rises by two after every cycle in which a pair was driven.
- R7: outEnable is high exactly in the cycles in which wordValid is nonzero; otherwise the bus is left floating.
- R8: A precharge to the open bank closes it. An activate at edge p+k after a precharge at edge p is accepted only when k >= TRP_CYC. An earlier activate is ignored and raises actViolation for the single cycle after that edge.
- R9: A read to the tracked bank while it is not open raises readError for one cycle and produces no data.
- R10: A read to the open bank, at any edge after an accepted read up to and including the edge that ends that read's window, raises readError and is ignored; the running burst continues unchanged.
- R11: A precharge to a bank that is not open is ignored and starts no recovery time, so an activate at the next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmd | input | 2 | Command code (0 none, 1 activate, 2 read, 3 precharge) |
| bankSel | input | BANK_W | Bank address of the command |
| wordValid | output | 2 | One strobe per word of the pair on the bus this cycle |
| outEnable | output | 1 | Data bus drive enable; low means the bus floats |
| wordCount | output | CNT_W | Words delivered by the latest burst |
| truncated | output | 1 | The latest finished burst delivered fewer than BURST_LEN words |
| actViolation | output | 1 | One-cycle pulse: activate rejected during precharge recovery |
| readError | output | 1 | One-cycle pulse: read rejected |
| bankActive | output | 1 | The tracked bank is open |

## Verification
The main pattern is a read followed by a precharge placed at every offset from one cycle after the read to past the end of the data window. The early offsets show where the cut point lands and how it scales with CAS latency. The offsets at and beyond the no-cut point show that a late precharge costs no data. A second sweep moves an activate across the recovery interval, which separates the last rejected edge from the first accepted one. Reads to a closed bank, reads overlapping a running burst, early precharges to a closed bank and commands to a different bank are each checked separately: each of these must leave the data window and the bank state untouched.

// File: rtl/rd_burst_pkg.sv
package rd_burst_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_READ = 2'd2,
    CMD_PRE  = 2'd3
  } dramCmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_RECOVER = 2'd2
  } bankState_e;

  // strobes from the bank controller to the burst datapath
  typedef struct packed {
    logic startRead;
    logic cutBurst;
  } burstStrobe_t;

endpackage

// File: rtl/rd_burst_ctrl.sv
module rd_burst_ctrl
  import rd_burst_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int TRACK_BANK = 0,
  parameter int TRP_CYC    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdIn,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              burstBusy,
  output burstStrobe_t      strobes,
  output logic              bankActive,
  output logic              actViolation,
  output logic              readError
);

  localparam int RP_W = (TRP_CYC > 1) ? $clog2(TRP_CYC + 1) : 1;
  localparam logic [RP_W-1:0] RP_LOAD = RP_W'(TRP_CYC - 1);
  localparam logic [RP_W-1:0] RP_LAST = RP_W'(1);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(TRACK_BANK);
  localparam bit HAS_RECOVER = (TRP_CYC > 1);

  bankState_e       bankState;
  logic [RP_W-1:0]  rpCnt;
  dramCmd_e         cmdE;
  logic             bankHit;
  logic             isAct, isRead, isPre;
  logic             actOk, actBad, readOk, readBad, preOk;

  assign cmdE    = dramCmd_e'(cmdIn);
  assign bankHit = (bankSel == MY_BANK);

  always_comb begin
    isAct   = bankHit && (cmdE == CMD_ACT);
    isRead  = bankHit && (cmdE == CMD_READ);
    isPre   = bankHit && (cmdE == CMD_PRE);
    actOk   = isAct && (bankState == BK_IDLE);
    actBad  = isAct && (bankState == BK_RECOVER);
    readOk  = isRead && (bankState == BK_OPEN) && !burstBusy;
    readBad = isRead && !readOk;
    preOk   = isPre && (bankState == BK_OPEN);
  end

  always_comb begin
    strobes           = '0;
    strobes.startRead = readOk;
    strobes.cutBurst  = preOk && burstBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankState    <= BK_IDLE;
      rpCnt        <= '0;
      actViolation <= 1'b0;
      readError    <= 1'b0;
    end else begin
      actViolation <= actBad;
      readError    <= readBad;
      unique case (bankState)
        BK_IDLE: begin
          if (actOk) bankState <= BK_OPEN;
        end
        BK_OPEN: begin
          if (preOk) begin
            rpCnt     <= RP_LOAD;
            bankState <= HAS_RECOVER ? BK_RECOVER : BK_IDLE;
          end
        end
        BK_RECOVER: begin
          rpCnt <= rpCnt - RP_LAST;
          if (rpCnt == RP_LAST) bankState <= BK_IDLE;
        end
        default: bankState <= BK_IDLE;
      endcase
    end
  end

  assign bankActive = (bankState == BK_OPEN);

endmodule

// File: rtl/rd_burst_dpath.sv
module rd_burst_dpath
  import rd_burst_pkg::*;
#(
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStrobe_t     strobes,
  output logic [1:0]       wordValid,
  output logic             outEnable,
  output logic [CNT_W-1:0] wordCount,
  output logic             truncated,
  output logic             burstBusy
);

  localparam int LANES = 2;
  localparam int PAIRS = BURST_LEN / LANES;
  localparam int AGE_W = $clog2(2 * CAS_LAT + PAIRS + 2);
  localparam logic [AGE_W-1:0] FIRST_AGE = AGE_W'(CAS_LAT);
  localparam logic [AGE_W-1:0] FULL_STOP = AGE_W'(CAS_LAT + PAIRS);
  localparam logic [AGE_W-1:0] CUT_OFS   = AGE_W'(CAS_LAT + 1);
  localparam logic [AGE_W-1:0] AGE_STEP  = AGE_W'(1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] CNT_STEP  = CNT_W'(LANES);

  logic [AGE_W-1:0] age;
  logic [AGE_W-1:0] stopAge;
  logic             busy;
  logic [AGE_W-1:0] ageNext, cutStop, stopNext;
  logic [CNT_W-1:0] cntNext;
  logic             pairLive, stillBusy;

  always_comb begin
    pairLive  = busy && (age >= FIRST_AGE) && (age < stopAge);
    ageNext   = age + AGE_STEP;
    cutStop   = age + CUT_OFS;
    stopNext  = (strobes.cutBurst && (cutStop < stopAge)) ? cutStop : stopAge;
    cntNext   = pairLive ? (wordCount + CNT_STEP) : wordCount;
    stillBusy = (ageNext < stopNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      age       <= '0;
      stopAge   <= FULL_STOP;
      busy      <= 1'b0;
      wordCount <= '0;
      truncated <= 1'b0;
    end else if (strobes.startRead) begin
      age       <= '0;
      stopAge   <= FULL_STOP;
      busy      <= 1'b1;
      wordCount <= '0;
      truncated <= 1'b0;
    end else if (busy) begin
      age       <= ageNext;
      stopAge   <= stopNext;
      wordCount <= cntNext;
      busy      <= stillBusy;
      if (!stillBusy) truncated <= (cntNext < FULL_CNT);
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign wordValid[lane] = pairLive;
  end

  assign outEnable = pairLive;
  assign burstBusy = busy;

endmodule

// File: rtl/rd_burst_tracker.sv
module rd_burst_tracker
  import rd_burst_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int TRACK_BANK = 0,
  parameter int CAS_LAT    = 2,
  parameter int BURST_LEN  = 8,
  parameter int TRP_CYC    = 3,
  parameter int CNT_W      = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bankSel,
  output logic [1:0]        wordValid,
  output logic              outEnable,
  output logic [CNT_W-1:0]  wordCount,
  output logic              truncated,
  output logic              actViolation,
  output logic              readError,
  output logic              bankActive
);

  burstStrobe_t strobes;
  logic         burstBusy;

  rd_burst_ctrl #(
    .BANK_W    (BANK_W),
    .TRACK_BANK(TRACK_BANK),
    .TRP_CYC   (TRP_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdIn       (cmd),
    .bankSel     (bankSel),
    .burstBusy   (burstBusy),
    .strobes     (strobes),
    .bankActive  (bankActive),
    .actViolation(actViolation),
    .readError   (readError)
  );

  rd_burst_dpath #(
    .CAS_LAT  (CAS_LAT),
    .BURST_LEN(BURST_LEN),
    .CNT_W    (CNT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wordValid(wordValid),
    .outEnable(outEnable),
    .wordCount(wordCount),
    .truncated(truncated),
    .burstBusy(burstBusy)
  );

endmodule

// File: rtl/rd_burst_checker.sv
module rd_burst_checker #(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       wordValid,
  input logic             outEnable,
  input logic [CNT_W-1:0] wordCount,
  input logic             truncated,
  input logic             actViolation,
  input logic             bankActive
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] PAIR_CNT = CNT_W'(2);

  AST_OE_TRACKS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    outEnable == (wordValid != 2'b00)); // R7

  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid == 2'b00) || (wordValid == 2'b11)); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wordCount <= FULL_CNT); // R6

  AST_TRUNC_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    truncated |-> (wordCount < FULL_CNT)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |=> (wordCount == $past(wordCount) + PAIR_CNT)); // R6

  AST_VIOL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    actViolation |-> !bankActive); // R8

endmodule

bind rd_burst_tracker rd_burst_checker #(
  .BURST_LEN(BURST_LEN),
  .CNT_W    (CNT_W)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .wordValid   (wordValid),
  .outEnable   (outEnable),
  .wordCount   (wordCount),
  .truncated   (truncated),
  .actViolation(actViolation),
  .bankActive  (bankActive)
);

// File: tb/rd_burst_tracker_test.sv
module rd_burst_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int CL  = 2;
  localparam int BL  = 8;
  localparam int TRP = 3;
  localparam int NPAIR = BL / 2;
  localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, PRE = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cmd = NOP;
  logic [1:0] bankSel = 2'd0;
  logic [1:0] wordValid;
  logic       outEnable;
  logic [3:0] wordCount;
  logic       truncated, actViolation, readError, bankActive;

  int nChecks = 0;
  int nFails  = 0;

  rd_burst_tracker #(
    .BANK_W(2), .TRACK_BANK(0), .CAS_LAT(CL), .BURST_LEN(BL), .TRP_CYC(TRP)
  ) uut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bankSel(bankSel),
    .wordValid(wordValid), .outEnable(outEnable), .wordCount(wordCount),
    .truncated(truncated), .actViolation(actViolation),
    .readError(readError), .bankActive(bankActive)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at the falling edge, take one rising edge, sample a quarter period later
  task automatic cyc(input logic [1:0] c, input logic [1:0] b);
    @(negedge clk);
    cmd = c;
    bankSel = b;
    @(posedge clk);
    #(CLK_PERIOD / 4);
  endtask

  task automatic waitRecover();
    for (int i = 0; i < TRP; i++) cyc(NOP, 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int expWords;
    int expPairs;
    int expValid;

    // R1 reset state
    for (int i = 0; i < 3; i++) cyc(NOP, 2'd0);
    chk("R1 outEnable", outEnable, 0);
    chk("R1 wordValid", wordValid, 0);
    chk("R1 wordCount", wordCount, 0);
    chk("R1 truncated", truncated, 0);
    chk("R1 bankActive", bankActive, 0);
    chk("R1 flags", {actViolation, readError}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R4 R5 R6: precharge swept across the read window
    for (int d = 1; d <= 7; d++) begin
      cyc(ACT, 2'd0);
      chk("R3 open", bankActive, 1);
      cyc(RD, 2'd0);
      chk("R6 count cleared", wordCount, 0);
      chk("R6 trunc cleared", truncated, 0);
      chk("R4 no data at read", wordValid, 0);
      for (int j = 1; j <= 8; j++) begin
        cyc((j == d) ? PRE : NOP, 2'd0);
        expValid = (j >= CL && j < CL + NPAIR && j < d + CL) ? 3 : 0;
        chk("R5 wordValid", wordValid, expValid);
        chk("R7 outEnable", outEnable, expValid != 0);
      end
      expPairs = (d < NPAIR) ? d : NPAIR;
      expWords = 2 * expPairs;
      chk("R6 wordCount", wordCount, expWords);
      chk("R6 truncated", truncated, expWords < BL);
      chk("R8 closed", bankActive, 0);
      waitRecover();
    end

    // R8 activate swept across recovery
    for (int k = 1; k <= 4; k++) begin
      cyc(ACT, 2'd0);
      cyc(PRE, 2'd0);
      chk("R8 closed by precharge", bankActive, 0);
      for (int i = 1; i < k; i++) cyc(NOP, 2'd0);
      cyc(ACT, 2'd0);
      chk("R8 activate accepted", bankActive, k >= TRP);
      chk("R8 violation", actViolation, k < TRP);
      cyc(NOP, 2'd0);
      chk("R8 violation one cycle", actViolation, 0);
      if (k >= TRP) cyc(PRE, 2'd0);
      waitRecover();
    end

    // R11 precharge to idle bank starts no recovery
    cyc(PRE, 2'd0);
    cyc(ACT, 2'd0);
    chk("R11 activate after idle precharge", bankActive, 1);
    chk("R11 no violation", actViolation, 0);
    cyc(PRE, 2'd0);
    waitRecover();

    // R9 read to closed bank
    cyc(RD, 2'd0);
    chk("R9 readError", readError, 1);
    for (int j = 1; j <= 6; j++) begin
      cyc(NOP, 2'd0);
      chk("R9 no data", outEnable, 0);
      chk("R9 error pulse", readError, 0);
    end
    chk("R9 bank stays closed", bankActive, 0);

    // R10 overlapping read rejected, burst intact
    cyc(ACT, 2'd0);
    cyc(RD, 2'd0);
    for (int j = 1; j <= 8; j++) begin
      cyc((j == 3 || j == 6) ? RD : NOP, 2'd0);
      if (j == 3 || j == 6) chk("R10 readError", readError, 1);
      expValid = (j >= CL && j < CL + NPAIR) ? 3 : 0;
      chk("R10 wordValid", wordValid, expValid);
    end
    chk("R10 wordCount", wordCount, BL);
    chk("R10 truncated", truncated, 0);

    // R2 other-bank commands ignored
    cyc(RD, 2'd0);
    for (int j = 1; j <= 8; j++) begin
      cyc((j == 1) ? PRE : ((j == 2) ? RD : NOP), 2'd1);
      if (j == 2) chk("R2 no error other bank", readError, 0);
      expValid = (j >= CL && j < CL + NPAIR) ? 3 : 0;
      chk("R2 wordValid", wordValid, expValid);
    end
    chk("R2 wordCount", wordCount, BL);
    chk("R2 truncated", truncated, 0);
    chk("R2 bank still open", bankActive, 1);
    cyc(PRE, 2'd0);
    waitRecover();
    cyc(ACT, 2'd2);
    chk("R2 activate other bank", bankActive, 0);
    cyc(RD, 2'd3);
    chk("R2 read other bank", readError, 0);
    cyc(NOP, 2'd0);
    cyc(NOP, 2'd0);
    chk("R2 no data", outEnable, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule